// File: doc/BRIEF.md
# Boot Mode Capture and On-Chip Memory Select

This block fixes the operating mode of a small controller from two strap pins. While reset is held it samples the pins on every clock and turns them into three mode-control bits. Once the block is running, the bits stay frozen until the next reset. From those bits, a 16-bit CPU address, an address-valid qualifier, a configuration ROM-enable bit and a 4-bit EEPROM page field, it produces chip selects for the on-chip ROM and the on-chip EEPROM.

A build parameter picks the EEPROM arrangement. One choice is a fixed 512-byte window. The other is a 2 KB window that software can place in the upper half of any 4 KB page. The block also drives an active-low strobe that marks the first cycle of every instruction.

Reset is asynchronous and active low. It is released into the block through a two-stage synchronizer. The internal run flag rises on the second rising clock edge after the reset input goes high.

Top module: `boot_mode_decode`

## Requirements
- R1: The strap pins decode into the mode bits {boot_rom, special, ext_bus} as follows. pin_b=1, pin_a=0 gives single-chip, 3'b000. pin_b=1, pin_a=1 gives expanded, 3'b001. pin_b=0, pin_a=0 gives bootstrap, 3'b110. pin_b=0, pin_a=1 gives special test, 3'b011.
- R2: The pins are sampled on every rising clock edge while the run flag is low. After the run flag is high, pin changes leave the mode bits unchanged.
- R3: In single-chip and bootstrap modes (ext_bus=0), rom_sel asserts for valid addresses 16'hE000 to 16'hFFFF, whatever the value of cfg_rom_en.
- R4: In expanded and special test modes (ext_bus=1), rom_sel asserts in the ROM window only when cfg_rom_en is 1.
- R5: In the fixed variant (EE_REMAP=0), ee_sel asserts exactly for 16'hB600 to 16'hB7FF, and cfg_ee_page has no effect.
- R6: In the remappable variant (EE_REMAP=1), ee_sel asserts when addr[15:12] equals cfg_ee_page and addr[11] is 1. A page value of 4'hF gives 16'hF800 to 16'hFFFF.
- R7: When an address falls in both windows, ee_sel asserts and rom_sel stays low. The two selects are never high together.
- R8: Both selects require addr_valid=1 and a high run flag. They are low while rst_n is low and for two rising edges after its release.
- R9: load_strobe_n is registered. It goes low on the rising edge that samples insn_start=1 while running, and it returns high on the next edge unless insn_start is sampled high again. It is high during reset, and insn_start has no effect while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_b | input | 1 | Strap pin B |
| pin_a | input | 1 | Strap pin A |
| addr | input | 16 | CPU address |
| addr_valid | input | 1 | Address qualifier |
| insn_start | input | 1 | First cycle of an instruction |
| cfg_rom_en | input | 1 | Configuration ROM enable |
| cfg_ee_page | input | 4 | EEPROM 4 KB page (remappable variant) |
| mode_boot_rom | output | 1 | Latched boot-ROM mode bit |
| mode_special | output | 1 | Latched special mode bit |
| mode_ext_bus | output | 1 | Latched external-bus mode bit |
| rom_sel | output | 1 | ROM chip select, active high |
| ee_sel | output | 1 | EEPROM chip select, active high |
| load_strobe_n | output | 1 | Instruction-start strobe, active low |

## Verification
The hardest condition to reach from the ports is the short window after reset is released. In that window the pins are still being sampled and the selects are still held low. The stimulus releases reset with a valid ROM address already applied. It then checks that the selects stay low after the first edge, rise after the second, and that pin changes made afterwards leave the mode bits untouched. A second instance built in the remappable variant shares the stimulus, so that the EEPROM and ROM windows overlap at page 4'hF and the priority can be compared against the fixed build.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE,
    MODE_EXPANDED,
    MODE_BOOTSTRAP,
    MODE_TEST
  } op_mode_e;

  typedef struct packed {
    logic boot_rom;
    logic special;
    logic ext_bus;
  } mode_bits_t;

  function automatic mode_bits_t pins_to_bits(input logic pin_b, input logic pin_a);
    mode_bits_t m;
    case ({pin_b, pin_a})
      2'b10:   m = '{boot_rom: 1'b0, special: 1'b0, ext_bus: 1'b0};
      2'b11:   m = '{boot_rom: 1'b0, special: 1'b0, ext_bus: 1'b1};
      2'b00:   m = '{boot_rom: 1'b1, special: 1'b1, ext_bus: 1'b0};
      default: m = '{boot_rom: 1'b0, special: 1'b1, ext_bus: 1'b1};
    endcase
    return m;
  endfunction

  function automatic op_mode_e bits_to_mode(input mode_bits_t m);
    if (m.boot_rom)     return MODE_BOOTSTRAP;
    else if (m.special) return MODE_TEST;
    else if (m.ext_bus) return MODE_EXPANDED;
    else                return MODE_SINGLE;
  endfunction

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign run = sh_q[STAGES-1];
endmodule

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       capture_en,
  input  logic       pin_b,
  input  logic       pin_a,
  output mode_bits_t bits_q
);
  mode_bits_t bits_d;

  always_comb begin
    bits_d = bits_q;
    if (capture_en) bits_d = pins_to_bits(pin_b, pin_a);
  end

  // Loaded by sampling during reset, so it carries no reset of its own.
  always_ff @(posedge clk) begin
    bits_q <= bits_d;
  end
endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode #(
  parameter int          ADDR_W      = 16,
  parameter int          PAGE_BITS   = 4,
  parameter bit          EE_REMAP    = 1'b0,
  parameter logic [15:0] ROM_BASE    = 16'hE000,
  parameter logic [15:0] EE_FIX_BASE = 16'hB600,
  parameter int          EE_FIX_SIZE = 512
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PAGE_BITS-1:0] page,
  input  logic                 enable,
  input  logic                 rom_allowed,
  output logic                 rom_sel,
  output logic                 ee_sel
);
  localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] EE_LO  = ADDR_W'(EE_FIX_BASE);
  localparam logic [ADDR_W-1:0] EE_HI  = ADDR_W'(EE_FIX_BASE + EE_FIX_SIZE - 1);
  localparam int                HALF_B = ADDR_W - PAGE_BITS - 1;

  logic rom_hit, fix_hit, remap_hit, ee_hit;

  always_comb begin
    rom_hit   = (addr >= ROM_LO);
    fix_hit   = (addr >= EE_LO) && (addr <= EE_HI);
    remap_hit = (addr[ADDR_W-1 -: PAGE_BITS] == page) && addr[HALF_B];
    ee_hit    = EE_REMAP ? remap_hit : fix_hit;
    ee_sel    = enable && ee_hit;
    rom_sel   = enable && rom_allowed && rom_hit && !ee_hit;
  end
endmodule

// File: rtl/boot_strobe_gen.sv
module boot_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic insn_start,
  output logic strobe_n
);
  logic strobe_d;

  always_comb strobe_d = !(run && insn_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_n <= 1'b1;
    else        strobe_n <= strobe_d;
  end
endmodule

// File: rtl/boot_mode_decode.sv
module boot_mode_decode
  import boot_pkg::*;
#(
  parameter bit EE_REMAP    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_b,
  input  logic        pin_a,
  input  logic [15:0] addr,
  input  logic        addr_valid,
  input  logic        insn_start,
  input  logic        cfg_rom_en,
  input  logic [3:0]  cfg_ee_page,
  output logic        mode_boot_rom,
  output logic        mode_special,
  output logic        mode_ext_bus,
  output logic        rom_sel,
  output logic        ee_sel,
  output logic        load_strobe_n
);
  logic       run_q;
  mode_bits_t bits_q;
  op_mode_e   op_mode;
  logic       rom_allowed;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(run_q)
  );

  boot_mode_latch u_latch (
    .clk(clk), .capture_en(!run_q), .pin_b(pin_b), .pin_a(pin_a), .bits_q(bits_q)
  );

  always_comb begin
    op_mode     = bits_to_mode(bits_q);
    rom_allowed = (op_mode == MODE_SINGLE) || (op_mode == MODE_BOOTSTRAP) || cfg_rom_en;
  end

  boot_addr_decode #(.EE_REMAP(EE_REMAP)) u_dec (
    .addr(addr), .page(cfg_ee_page), .enable(run_q && rst_n && addr_valid),
    .rom_allowed(rom_allowed), .rom_sel(rom_sel), .ee_sel(ee_sel)
  );

  boot_strobe_gen u_strb (
    .clk(clk), .rst_n(rst_n), .run(run_q), .insn_start(insn_start), .strobe_n(load_strobe_n)
  );

  assign mode_boot_rom = bits_q.boot_rom;
  assign mode_special  = bits_q.special;
  assign mode_ext_bus  = bits_q.ext_bus;
endmodule

// File: rtl/boot_mode_decode_chk.sv
module boot_mode_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [15:0] addr,
  input logic        addr_valid,
  input logic        insn_start,
  input logic        cfg_rom_en,
  input logic        mode_boot_rom,
  input logic        mode_special,
  input logic        mode_ext_bus,
  input logic        rom_sel,
  input logic        ee_sel,
  input logic        load_strobe_n
);
  logic [2:0] mb;
  assign mb = {mode_boot_rom, mode_special, mode_ext_bus};

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (mb == 3'b000 || mb == 3'b001 || mb == 3'b110 || mb == 3'b011));

  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(mb));

  p_rom_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && addr_valid && addr[15:13] == 3'b111 && !ee_sel && !mode_ext_bus) |-> rom_sel);

  p_rom_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && mode_ext_bus) |-> cfg_rom_en);

  p_sel_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ee_sel));

  p_sel_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel || ee_sel) |-> (addr_valid && run));

  always @(negedge clk) begin
    if (!rst_n) begin
      p_idle_in_reset_r8: assert (!rom_sel && !ee_sel && load_strobe_n);
    end
  end

  p_strobe_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && insn_start) |=> !load_strobe_n);

  p_strobe_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && insn_start) |=> load_strobe_n);
endmodule

bind boot_mode_decode boot_mode_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .addr(addr), .addr_valid(addr_valid),
  .insn_start(insn_start), .cfg_rom_en(cfg_rom_en), .mode_boot_rom(mode_boot_rom),
  .mode_special(mode_special), .mode_ext_bus(mode_ext_bus), .rom_sel(rom_sel),
  .ee_sel(ee_sel), .load_strobe_n(load_strobe_n)
);

// File: tb/sim_boot_mode_decode.sv
`timescale 1ns/1ps
module sim_boot_mode_decode;
  logic        clk;
  logic        rst_n;
  logic        pin_b, pin_a;
  logic [15:0] addr;
  logic        addr_valid, insn_start, cfg_rom_en;
  logic [3:0]  cfg_ee_page;
  logic        mb0_b, mb0_s, mb0_e, rs0, es0, ls0;
  logic        mb1_b, mb1_s, mb1_e, rs1, es1, ls1;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          timed_out = 0;

  boot_mode_decode #(.EE_REMAP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_b(pin_b), .pin_a(pin_a), .addr(addr),
    .addr_valid(addr_valid), .insn_start(insn_start), .cfg_rom_en(cfg_rom_en),
    .cfg_ee_page(cfg_ee_page), .mode_boot_rom(mb0_b), .mode_special(mb0_s),
    .mode_ext_bus(mb0_e), .rom_sel(rs0), .ee_sel(es0), .load_strobe_n(ls0));

  boot_mode_decode #(.EE_REMAP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pin_b(pin_b), .pin_a(pin_a), .addr(addr),
    .addr_valid(addr_valid), .insn_start(insn_start), .cfg_rom_en(cfg_rom_en),
    .cfg_ee_page(cfg_ee_page), .mode_boot_rom(mb1_b), .mode_special(mb1_s),
    .mode_ext_bus(mb1_e), .rom_sel(rs1), .ee_sel(es1), .load_strobe_n(ls1));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_bits(input logic b, input logic a);
    case ({b, a})
      2'b10:   return 3'b000;
      2'b11:   return 3'b001;
      2'b00:   return 3'b110;
      default: return 3'b011;
    endcase
  endfunction

  task automatic do_reset(input logic b, input logic a);
    @(negedge clk);
    rst_n = 1'b0; pin_b = b; pin_a = a; addr_valid = 1'b0; insn_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic set_addr(input logic [15:0] a, input logic v);
    @(negedge clk);
    addr = a; addr_valid = v;
    #1;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0; pin_b = 1'b1; pin_a = 1'b0; addr = 16'hE000; addr_valid = 1'b1;
    cfg_rom_en = 1'b1; insn_start = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R8", "rom_sel in reset", rs0, 1'b0);
    check("R9", "strobe in reset despite insn_start", ls0, 1'b1);
    insn_start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8", "rom_sel at release", rs0, 1'b0);
    @(negedge clk); #1;
    check("R8", "rom_sel after one edge", rs0, 1'b0);
    @(negedge clk); #1;
    check("R8", "rom_sel after two edges", rs0, 1'b1);
  endtask

  task automatic t_mode_decode;
    for (int k = 0; k < 4; k++) begin
      logic b, a;
      b = k[1]; a = k[0];
      do_reset(b, a);
      check("R1", $sformatf("mode bits u0 pins %0d", k), {mb0_b, mb0_s, mb0_e}, exp_bits(b, a));
      check("R1", $sformatf("mode bits u1 pins %0d", k), {mb1_b, mb1_s, mb1_e}, exp_bits(b, a));
    end
  endtask

  task automatic t_freeze;
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pin_b = k[1]; pin_a = k[0];
      @(negedge clk); #1;
      check("R2", $sformatf("bits after pin change %0d", k), {mb0_b, mb0_s, mb0_e}, 3'b110);
    end
  endtask

  task automatic t_rom_gating;
    cfg_ee_page = 4'h3;
    do_reset(1'b1, 1'b0);
    cfg_rom_en = 1'b0;
    set_addr(16'hE000, 1'b1); check("R3", "single-chip E000 rom off cfg", rs0, 1'b1);
    set_addr(16'hFFFF, 1'b1); check("R3", "single-chip FFFF", rs0, 1'b1);
    set_addr(16'hDFFF, 1'b1); check("R3", "single-chip DFFF", rs0, 1'b0);
    do_reset(1'b0, 1'b0);
    set_addr(16'hF000, 1'b1); check("R3", "bootstrap F000 rom off cfg", rs0, 1'b1);
    do_reset(1'b1, 1'b1);
    cfg_rom_en = 1'b0;
    set_addr(16'hE000, 1'b1); check("R4", "expanded cfg 0", rs0, 1'b0);
    cfg_rom_en = 1'b1; #1;    check("R4", "expanded cfg 1", rs0, 1'b1);
    do_reset(1'b0, 1'b1);
    cfg_rom_en = 1'b0;
    set_addr(16'hFFFE, 1'b1); check("R4", "test cfg 0", rs0, 1'b0);
    cfg_rom_en = 1'b1; #1;    check("R4", "test cfg 1", rs0, 1'b1);
    set_addr(16'hFFFE, 1'b0); check("R8", "rom_sel without addr_valid", rs0, 1'b0);
  endtask

  task automatic t_eeprom;
    do_reset(1'b1, 1'b0);
    cfg_ee_page = 4'hB;
    set_addr(16'hB5FF, 1'b1); check("R5", "fixed B5FF", es0, 1'b0);
    set_addr(16'hB600, 1'b1); check("R5", "fixed B600", es0, 1'b1);
    set_addr(16'hB7FF, 1'b1); check("R5", "fixed B7FF", es0, 1'b1);
    set_addr(16'hB800, 1'b1); check("R5", "fixed B800 page B ignored", es0, 1'b0);
    set_addr(16'hB7FF, 1'b0); check("R8", "ee_sel without addr_valid", es0, 1'b0);
    cfg_ee_page = 4'h3;
    set_addr(16'h3800, 1'b1); check("R5", "fixed ignores page 3", es0, 1'b0);
    check("R6", "remap 3800", es1, 1'b1);
    set_addr(16'h3FFF, 1'b1); check("R6", "remap 3FFF", es1, 1'b1);
    set_addr(16'h37FF, 1'b1); check("R6", "remap 37FF", es1, 1'b0);
    set_addr(16'h4800, 1'b1); check("R6", "remap 4800", es1, 1'b0);
    cfg_ee_page = 4'hF;
    set_addr(16'hF7FF, 1'b1); check("R6", "remap page F F7FF", es1, 1'b0);
    set_addr(16'hF800, 1'b1); check("R6", "remap page F F800", es1, 1'b1);
  endtask

  task automatic t_overlap;
    do_reset(1'b1, 1'b0);
    cfg_ee_page = 4'hF;
    set_addr(16'hFC00, 1'b1);
    check("R7", "remap overlap ee_sel", es1, 1'b1);
    check("R7", "remap overlap rom_sel", rs1, 1'b0);
    check("R7", "fixed no overlap rom_sel", rs0, 1'b1);
    set_addr(16'hF400, 1'b1);
    check("R7", "remap F400 rom_sel", rs1, 1'b1);
  endtask

  task automatic t_strobe;
    do_reset(1'b1, 1'b1);
    check("R9", "strobe idle", ls0, 1'b1);
    @(negedge clk); insn_start = 1'b1;
    @(negedge clk); insn_start = 1'b0; #1;
    check("R9", "strobe low after start", ls0, 1'b0);
    check("R9", "strobe low u1", ls1, 1'b0);
    @(negedge clk); #1;
    check("R9", "strobe back high", ls0, 1'b1);
    @(negedge clk); #1;
    check("R9", "strobe stays high", ls0, 1'b1);
  endtask

  task automatic run_all;
    t_reset_state();
    t_mode_decode();
    t_freeze();
    t_rom_gating();
    t_eeprom();
    t_overlap();
    t_strobe();
  endtask

  initial begin
    rst_n = 1'b0; pin_b = 1'b1; pin_a = 1'b0; addr = '0; addr_valid = 1'b0;
    insn_start = 1'b0; cfg_rom_en = 1'b0; cfg_ee_page = 4'hF;
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule